// File: doc/BRIEF.md
# Control Endpoint Handshake Controller

This block runs endpoint zero of a USB device during control transfers. On one side it takes already-decoded traffic from a serial interface engine. That traffic is a token strobe with its type and endpoint number, a stream of received data bytes, and an end-of-packet strobe that carries a CRC verdict and the DATA0/DATA1 toggle. For each transaction it returns one handshake decision: ACK, NAK or STALL. On the other side, a small CPU register port exposes four things: the eight captured SETUP bytes, two interrupt request flags, a control register with a stall bit and a hold-release bit, and two byte-count registers that arm the data stage.

After a SETUP packet is accepted, the block works out from the request bytes whether a data stage exists and which way it flows. From that it knows which token direction belongs to the STATUS stage. Every STATUS-stage token gets a NAK until the CPU releases the hold, so the host cannot finish the transfer while firmware is still reconfiguring. A stall takes effect only when the stall bit and the release bit are both set. A SETUP packet is always accepted, and it restarts the whole sequence.

Top module: `ep0_ctrl_hs`

## Requirements
- R1: After reset, hs_valid is 0, both interrupt flags are 0, the control register (address 8) reads 0 and all eight setup bytes (addresses 0..7) read 0.
- R2: A token with tok_pid=2 (SETUP) and tok_ep=0 sets irq_setup_tok on the next clock edge. Tokens for any other endpoint produce no handshake and change no flag.
- R3: When an end-of-packet closes a SETUP data packet with exactly eight bytes, rx_crc_ok=1 and rx_data1=0, the setup buffer takes the bytes and irq_setup_data is set. A handshake with hs_code=1 (ACK) appears on the same edge. This happens whatever the stall bit holds.
- R4: A SETUP data packet with a bad CRC, a DATA1 toggle or a byte count other than eight gets no handshake and does not set irq_setup_data. The setup buffer keeps its previous contents.
- R5: Each IN (tok_pid=1) or OUT (tok_pid=0) token gets one handshake on the edge that samples it: 1=ACK, 2=NAK, 3=STALL. A STATUS-stage token gets NAK while the hold is not released.
- R6: Writing address 8 with bit 1 set releases the hold. The next STATUS-stage token then gets ACK and ends the transfer. Later tokens are treated as data-stage tokens.
- R7: The STATUS stage runs opposite to setup byte 0 bit 7 (1 = IN data stage) when the length field is non-zero. The length field is bytes 6 and 7, little-endian. When the length is zero, the STATUS stage is IN.
- R8: A data-stage token gets ACK only when its direction is armed, and the ACK disarms that direction. A write to address 10 arms IN and a write to address 11 arms OUT; the written value is kept as the byte count. An unarmed data-stage token gets NAK.
- R9: An IN or OUT token on endpoint zero gets STALL exactly when both the stall bit (address 8 bit 0) and the release bit are set. The stall bit alone does not change the response.
- R10: A SETUP token clears the stall bit, the release bit and both arming flags. This aborts any transfer in progress. Address 8 reads {out_armed, in_armed, release, stall} in bits 3..0.
- R11: Address 9 reads {irq_setup_data, irq_setup_tok} in bits 1..0. Writing 1 to a bit clears that flag and writing 0 leaves it. A set in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tok_valid | input | 1 | Token strobe, one cycle |
| tok_pid | input | 2 | Token type: 0 OUT, 1 IN, 2 SETUP |
| tok_ep | input | 4 | Token endpoint number |
| rx_byte_valid | input | 1 | Received data byte strobe |
| rx_byte | input | 8 | Received data byte |
| rx_eop | input | 1 | End of data packet strobe |
| rx_crc_ok | input | 1 | CRC verdict, valid with rx_eop |
| rx_data1 | input | 1 | Packet was DATA1, valid with rx_eop |
| hs_valid | output | 1 | Handshake decision strobe |
| hs_code | output | 2 | 1 ACK, 2 NAK, 3 STALL |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_addr | input | 4 | CPU register address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data for cpu_addr, combinational |
| irq_setup_tok | output | 1 | SETUP token interrupt request |
| irq_setup_data | output | 1 | Setup data available interrupt request |

## Verification
The hardest state to reach is a STALL on the STATUS stage. It needs an accepted SETUP packet that fixes the status direction, then both CPU bits written, then a token in exactly the status direction. The stimulus first drives a token with only the stall bit set and expects NAK. It then sets the release bit and expects STALL. After that, a fresh SETUP is sent with the stall bit still set, which shows the SETUP being accepted and the bits being cleared. The rejected SETUP packets (bad CRC, seven bytes, DATA1) are sent right after a good one, so an unchanged buffer is visible in the read-back.

// File: rtl/ep0_pkg.sv
// Package: shared codes for the endpoint-zero handshake controller.
// Assumes the serial engine reports token types with the 2-bit codes below.
package ep0_pkg;
    typedef enum logic [1:0] {
        TK_OUT   = 2'd0,
        TK_IN    = 2'd1,
        TK_SETUP = 2'd2,
        TK_RSVD  = 2'd3
    } tok_t;

    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_t;

    localparam int unsigned REG_CTRL  = 8;
    localparam int unsigned REG_IRQ   = 9;
    localparam int unsigned REG_INBC  = 10;
    localparam int unsigned REG_OUTBC = 11;
endpackage

// File: rtl/ep0_setup_capture.sv
// Module: ep0_setup_capture
// Collects the bytes of a SETUP data packet into a staging register and
// commits them to the readable buffer only when the packet closes with a good
// CRC, a DATA0 toggle and exactly NBYTES bytes.
// Assumes rx_eop arrives in a cycle of its own, after the last byte.
module ep0_setup_capture #(
    parameter int unsigned NBYTES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  byte_valid,
    input  logic [7:0]            byte_in,
    input  logic                  eop,
    input  logic                  crc_ok,
    input  logic                  data1,
    output logic                  commit,
    output logic                  su_dir_in,
    output logic                  su_len_nz,
    output logic [NBYTES*8-1:0]   buf_q
);
    localparam int unsigned CNT_W = $clog2(NBYTES + 2);
    localparam int unsigned BITS  = NBYTES * 8;

    logic              cap_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BITS-1:0]   stage_q;

    // A packet is accepted only when every condition of a clean SETUP holds.
    assign commit    = cap_q && eop && crc_ok && !data1 && (cnt_q == CNT_W'(NBYTES));
    // Request direction and length come from the staged bytes being committed.
    assign su_dir_in = stage_q[7];
    assign su_len_nz = |stage_q[BITS-1 -: 16];

    // Capture window: opened by a SETUP token, closed by any end of packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            cap_q <= 1'b1;
            cnt_q <= '0;
        end else if (cap_q && eop) begin
            cap_q <= 1'b0;
        end else if (cap_q && byte_valid && cnt_q <= CNT_W'(NBYTES)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Staging register: byte i lands in lane i; extra bytes are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (cap_q && byte_valid && !start) begin
            for (int i = 0; i < NBYTES; i++) begin
                if (cnt_q == CNT_W'(i)) stage_q[i*8 +: 8] <= byte_in;
            end
        end
    end

    // Readable buffer: updated only on an accepted packet.
    always_ff @(posedge clk) begin
        if (!rst_n) buf_q <= '0;
        else if (commit) buf_q <= stage_q;
    end
endmodule

// File: rtl/ep0_stage_ctrl.sv
// Module: ep0_stage_ctrl
// Tracks the control transfer stage and decides the handshake for every
// endpoint-zero transaction. Decisions use the register state before the edge.
// Assumes CPU writes and tokens do not fall in the same cycle in normal use.
module ep0_stage_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tok_hit,
    input  logic [1:0] tok_pid,
    input  logic       commit,
    input  logic       su_dir_in,
    input  logic       su_len_nz,
    input  logic       stall,
    input  logic       release_q,
    input  logic       in_armed,
    input  logic       out_armed,
    output logic       ack_in,
    output logic       ack_out,
    output logic       hs_valid,
    output logic [1:0] hs_code
);
    import ep0_pkg::*;

    logic       active_q;
    logic       stat_in_q;
    logic       is_in;
    logic       is_data_tok;
    logic       is_status;
    logic       armed_dir;
    logic       dec_valid;
    logic [1:0] dec_code;
    logic       status_done;

    assign is_in       = (tok_pid == TK_IN);
    assign is_data_tok = tok_hit && (tok_pid == TK_IN || tok_pid == TK_OUT);
    assign is_status   = active_q && (is_in == stat_in_q);
    assign armed_dir   = is_in ? in_armed : out_armed;

    // Handshake decision for the transaction sampled this cycle.
    always_comb begin
        dec_valid   = 1'b0;
        dec_code    = HS_NONE;
        status_done = 1'b0;
        ack_in      = 1'b0;
        ack_out     = 1'b0;
        if (commit) begin
            dec_valid = 1'b1;
            dec_code  = HS_ACK;
        end else if (is_data_tok) begin
            dec_valid = 1'b1;
            if (stall && release_q) begin
                dec_code = HS_STALL;
            end else if (is_status) begin
                dec_code    = release_q ? HS_ACK : HS_NAK;
                status_done = release_q;
            end else if (armed_dir) begin
                dec_code = HS_ACK;
                ack_in   = is_in;
                ack_out  = !is_in;
            end else begin
                dec_code = HS_NAK;
            end
        end
    end

    // Stage state: a transfer is live from an accepted SETUP to its status ACK.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= 1'b0;
            stat_in_q <= 1'b1;
        end else if (tok_hit && tok_pid == TK_SETUP) begin
            active_q <= 1'b0;
        end else if (commit) begin
            active_q  <= 1'b1;
            stat_in_q <= su_len_nz ? !su_dir_in : 1'b1;
        end else if (status_done) begin
            active_q <= 1'b0;
        end
    end

    // Registered handshake output, one cycle per decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_valid <= 1'b0;
            hs_code  <= HS_NONE;
        end else begin
            hs_valid <= dec_valid;
            hs_code  <= dec_code;
        end
    end
endmodule

// File: rtl/ep0_cpu_regs.sv
// Module: ep0_cpu_regs
// CPU-visible registers: setup bytes, control bits, interrupt flags and the
// two data-stage byte counts. The read port is combinational.
// Assumes a SETUP token outranks any CPU write to the bits it clears.
module ep0_cpu_regs #(
    parameter int unsigned NBYTES = 8,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned BC_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_wr,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic [7:0]           cpu_wdata,
    output logic [7:0]           cpu_rdata,
    input  logic                 setup_tok,
    input  logic                 commit,
    input  logic                 ack_in,
    input  logic                 ack_out,
    input  logic [NBYTES*8-1:0]  buf_q,
    output logic                 stall_q,
    output logic                 release_q,
    output logic                 in_armed_q,
    output logic                 out_armed_q,
    output logic                 irq_tok_q,
    output logic                 irq_dat_q
);
    import ep0_pkg::*;

    logic            wr_ctrl, wr_irq, wr_inbc, wr_outbc;
    logic [BC_W-1:0] in_bc_q, out_bc_q;

    assign wr_ctrl  = cpu_wr && cpu_addr == ADDR_W'(REG_CTRL);
    assign wr_irq   = cpu_wr && cpu_addr == ADDR_W'(REG_IRQ);
    assign wr_inbc  = cpu_wr && cpu_addr == ADDR_W'(REG_INBC);
    assign wr_outbc = cpu_wr && cpu_addr == ADDR_W'(REG_OUTBC);

    // Control bits: a SETUP token wipes them; release is set-only by the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n || setup_tok) begin
            stall_q   <= 1'b0;
            release_q <= 1'b0;
        end else if (wr_ctrl) begin
            stall_q   <= cpu_wdata[0];
            release_q <= release_q | cpu_wdata[1];
        end
    end

    // Arming flags and counts: written by the CPU, cleared by the ACK or a SETUP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_armed_q  <= 1'b0;
            out_armed_q <= 1'b0;
            in_bc_q     <= '0;
            out_bc_q    <= '0;
        end else begin
            if (setup_tok)     in_armed_q <= 1'b0;
            else if (wr_inbc)  in_armed_q <= 1'b1;
            else if (ack_in)   in_armed_q <= 1'b0;
            if (setup_tok)     out_armed_q <= 1'b0;
            else if (wr_outbc) out_armed_q <= 1'b1;
            else if (ack_out)  out_armed_q <= 1'b0;
            if (wr_inbc)  in_bc_q  <= cpu_wdata[BC_W-1:0];
            if (wr_outbc) out_bc_q <= cpu_wdata[BC_W-1:0];
        end
    end

    // Interrupt flags: hardware set wins over a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_tok_q <= 1'b0;
            irq_dat_q <= 1'b0;
        end else begin
            irq_tok_q <= setup_tok | (irq_tok_q & ~(wr_irq & cpu_wdata[0]));
            irq_dat_q <= commit    | (irq_dat_q & ~(wr_irq & cpu_wdata[1]));
        end
    end

    // Read multiplexer over the register map.
    always_comb begin
        cpu_rdata = 8'h00;
        for (int i = 0; i < NBYTES; i++) begin
            if (cpu_addr == ADDR_W'(i)) cpu_rdata = buf_q[i*8 +: 8];
        end
        if (cpu_addr == ADDR_W'(REG_CTRL))
            cpu_rdata = {4'h0, out_armed_q, in_armed_q, release_q, stall_q};
        if (cpu_addr == ADDR_W'(REG_IRQ))
            cpu_rdata = {6'h00, irq_dat_q, irq_tok_q};
        if (cpu_addr == ADDR_W'(REG_INBC))  cpu_rdata = 8'(in_bc_q);
        if (cpu_addr == ADDR_W'(REG_OUTBC)) cpu_rdata = 8'(out_bc_q);
    end
endmodule

// File: rtl/ep0_ctrl_hs.sv
// Module: ep0_ctrl_hs (top)
// Endpoint-zero control transfer handshake controller. Joins the setup
// capture, the stage tracker and the CPU registers.
// Assumes decoded packets from a serial engine and one transaction at a time.
module ep0_ctrl_hs #(
    parameter int unsigned NBYTES = 8,
    parameter int unsigned EP_W   = 4,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned BC_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    input  logic [1:0]        tok_pid,
    input  logic [EP_W-1:0]   tok_ep,
    input  logic              rx_byte_valid,
    input  logic [7:0]        rx_byte,
    input  logic              rx_eop,
    input  logic              rx_crc_ok,
    input  logic              rx_data1,
    output logic              hs_valid,
    output logic [1:0]        hs_code,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic              irq_setup_tok,
    output logic              irq_setup_data
);
    import ep0_pkg::*;

    logic                tok_hit, setup_tok, commit, su_dir_in, su_len_nz;
    logic                stall_q, release_q, in_armed_q, out_armed_q;
    logic                ack_in, ack_out;
    logic [NBYTES*8-1:0] buf_q;

    assign tok_hit   = tok_valid && (tok_ep == '0);
    assign setup_tok = tok_hit && (tok_pid == TK_SETUP);

    ep0_setup_capture #(.NBYTES(NBYTES)) u_cap (
        .clk(clk), .rst_n(rst_n), .start(setup_tok),
        .byte_valid(rx_byte_valid), .byte_in(rx_byte), .eop(rx_eop),
        .crc_ok(rx_crc_ok), .data1(rx_data1), .commit(commit),
        .su_dir_in(su_dir_in), .su_len_nz(su_len_nz), .buf_q(buf_q)
    );

    ep0_stage_ctrl u_stage (
        .clk(clk), .rst_n(rst_n), .tok_hit(tok_hit), .tok_pid(tok_pid),
        .commit(commit), .su_dir_in(su_dir_in), .su_len_nz(su_len_nz),
        .stall(stall_q), .release_q(release_q), .in_armed(in_armed_q),
        .out_armed(out_armed_q), .ack_in(ack_in), .ack_out(ack_out),
        .hs_valid(hs_valid), .hs_code(hs_code)
    );

    ep0_cpu_regs #(.NBYTES(NBYTES), .ADDR_W(ADDR_W), .BC_W(BC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .setup_tok(setup_tok),
        .commit(commit), .ack_in(ack_in), .ack_out(ack_out), .buf_q(buf_q),
        .stall_q(stall_q), .release_q(release_q), .in_armed_q(in_armed_q),
        .out_armed_q(out_armed_q), .irq_tok_q(irq_setup_tok),
        .irq_dat_q(irq_setup_data)
    );
endmodule

// File: rtl/ep0_ctrl_hs_chk.sv
// Module: ep0_ctrl_hs_chk
// Temporal checks on the handshake controller, bound into every instance.
module ep0_ctrl_hs_chk #(
    parameter int unsigned EP_W   = 4,
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tok_valid,
    input logic [1:0]        tok_pid,
    input logic [EP_W-1:0]   tok_ep,
    input logic              rx_eop,
    input logic              rx_crc_ok,
    input logic              rx_data1,
    input logic              hs_valid,
    input logic [1:0]        hs_code,
    input logic              cpu_wr,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [7:0]        cpu_wdata,
    input logic              irq_setup_tok,
    input logic              irq_setup_data,
    input logic              stall,
    input logic              rel
);
    assert_hs_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |-> $past(tok_valid || rx_eop));

    assert_sutok_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_pid == 2'd2 && tok_ep == '0) |=> irq_setup_tok);

    assert_sudav_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_setup_data) |-> $past(rx_eop && rx_crc_ok && !rx_data1));

    assert_setup_not_stalled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_code == 2'd3) |-> $past(tok_valid && tok_pid != 2'd2));

    assert_stall_needs_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_code == 2'd3) |-> $past(stall && rel));

    assert_setup_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_pid == 2'd2 && tok_ep == '0) |=> (!stall && !rel));

    assert_w1c_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_setup_tok && !(cpu_wr && cpu_addr == ADDR_W'(9) && cpu_wdata[0]))
        |=> irq_setup_tok);
endmodule

bind ep0_ctrl_hs ep0_ctrl_hs_chk #(.EP_W(EP_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_pid(tok_pid),
    .tok_ep(tok_ep), .rx_eop(rx_eop), .rx_crc_ok(rx_crc_ok),
    .rx_data1(rx_data1), .hs_valid(hs_valid), .hs_code(hs_code),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .irq_setup_tok(irq_setup_tok), .irq_setup_data(irq_setup_data),
    .stall(stall_q), .rel(release_q)
);

// File: tb/test_ep0_ctrl_hs.sv
module test_ep0_ctrl_hs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tok_valid = 1'b0;
    logic [1:0] tok_pid = 2'd0;
    logic [3:0] tok_ep = 4'd0;
    logic       rx_byte_valid = 1'b0;
    logic [7:0] rx_byte = 8'd0;
    logic       rx_eop = 1'b0;
    logic       rx_crc_ok = 1'b0;
    logic       rx_data1 = 1'b0;
    logic       hs_valid;
    logic [1:0] hs_code;
    logic       cpu_wr = 1'b0;
    logic [3:0] cpu_addr = 4'd0;
    logic [7:0] cpu_wdata = 8'd0;
    logic [7:0] cpu_rdata;
    logic       irq_setup_tok, irq_setup_data;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int last_v, last_c;

    ep0_ctrl_hs i_ep0_ctrl_hs (.*);

    always #10 clk = ~clk;   // 50 MHz

    // Behavioural reference model state
    int m_hv, m_hc, m_tok, m_dat, m_stall, m_rel, m_ina, m_outa;
    int m_active, m_statin, m_cap, m_cnt;
    int m_stage[8];
    int m_buf[8];

    always @(posedge clk) begin
        int nv, nc, isin, st, arm;
        if (!rst_n) begin
            m_hv = 0; m_hc = 0; m_tok = 0; m_dat = 0; m_stall = 0; m_rel = 0;
            m_ina = 0; m_outa = 0; m_active = 0; m_statin = 1; m_cap = 0; m_cnt = 0;
            for (int i = 0; i < 8; i++) begin m_stage[i] = 0; m_buf[i] = 0; end
        end else begin
            nv = 0; nc = 0;
            if (cpu_wr) begin
                if (cpu_addr == 8) begin m_stall = cpu_wdata[0]; if (cpu_wdata[1]) m_rel = 1; end
                if (cpu_addr == 9) begin
                    if (cpu_wdata[0]) m_tok = 0;
                    if (cpu_wdata[1]) m_dat = 0;
                end
                if (cpu_addr == 10) m_ina = 1;
                if (cpu_addr == 11) m_outa = 1;
            end
            if (tok_valid && tok_ep == 0 && tok_pid == 2) begin
                m_tok = 1; m_stall = 0; m_rel = 0; m_ina = 0; m_outa = 0;
                m_active = 0; m_cap = 1; m_cnt = 0;
            end else if (tok_valid && tok_ep == 0 && tok_pid < 2) begin
                isin = (tok_pid == 1);
                st = m_active && (isin == m_statin);
                arm = isin ? m_ina : m_outa;
                nv = 1;
                if (m_stall && m_rel) nc = 3;
                else if (st) begin
                    if (m_rel) begin nc = 1; m_active = 0; end else nc = 2;
                end else if (arm) begin
                    nc = 1;
                    if (isin) m_ina = 0; else m_outa = 0;
                end else nc = 2;
            end else if (m_cap && rx_eop) begin
                if (rx_crc_ok && !rx_data1 && m_cnt == 8) begin
                    for (int i = 0; i < 8; i++) m_buf[i] = m_stage[i];
                    m_dat = 1; nv = 1; nc = 1; m_active = 1;
                    if ((m_stage[6] | m_stage[7]) != 0) m_statin = (m_stage[0] >= 128) ? 0 : 1;
                    else m_statin = 1;
                end
                m_cap = 0;
            end else if (m_cap && rx_byte_valid) begin
                if (m_cnt < 8) m_stage[m_cnt] = rx_byte;
                if (m_cnt < 9) m_cnt++;
            end
            m_hv = nv; m_hc = nc;
        end
    end

    // Every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            total++;
            if (hs_valid != m_hv || (m_hv && hs_code != m_hc)) begin
                bad++;
                $display("FAIL R5 model handshake: act v=%0d c=%0d exp v=%0d c=%0d",
                         hs_valid, hs_code, m_hv, m_hc);
            end
            total++;
            if (irq_setup_tok != m_tok || irq_setup_data != m_dat) begin
                bad++;
                $display("FAIL R11 model irq: act %0d%0d exp %0d%0d",
                         irq_setup_data, irq_setup_tok, m_dat, m_tok);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic token(input int pid, input int ep);
        @(negedge clk);
        tok_valid = 1; tok_pid = 2'(pid); tok_ep = 4'(ep);
        @(negedge clk);
        last_v = hs_valid; last_c = hs_code;
        tok_valid = 0;
    endtask

    // Handshake code expected on a token, 0 meaning none
    task automatic tok_expect(input string tag, input int pid, input int ep, input int exp);
        token(pid, ep);
        chk(tag, last_v ? last_c : 0, exp);
    endtask

    task automatic setup_pkt(input logic [63:0] b, input int n, input int crc, input int d1);
        token(2, 0);
        for (int i = 0; i < n; i++) begin
            rx_byte_valid = 1; rx_byte = b[i*8 +: 8];
            @(negedge clk);
        end
        rx_byte_valid = 0;
        rx_eop = 1; rx_crc_ok = 1'(crc); rx_data1 = 1'(d1);
        @(negedge clk);
        last_v = hs_valid; last_c = hs_code;
        rx_eop = 0; rx_crc_ok = 0; rx_data1 = 0;
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cpu_wr = 1; cpu_addr = 4'(a); cpu_wdata = 8'(d);
        @(negedge clk);
        cpu_wr = 0;
    endtask

    task automatic rd(input string tag, input int a, input int exp);
        cpu_addr = 4'(a);
        #1;
        chk(tag, cpu_rdata, exp);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 hs_valid", hs_valid, 0);
        chk("R1 irq", {irq_setup_data, irq_setup_tok}, 0);
        rd("R1 ctrl", 8, 0);
        rd("R1 byte0", 0, 0);
        rd("R1 byte7", 7, 0);

        // R2 other endpoint ignored
        tok_expect("R2 other ep no hs", 1, 3, 0);
        tok_expect("R2 other ep setup", 2, 5, 0);
        chk("R2 other ep no flag", irq_setup_tok, 0);

        // R3 good IN-data setup, length 0x12
        setup_pkt(64'h0012_0000_0100_0680, 8, 1, 0);
        chk("R2 sutok set", irq_setup_tok, 1);
        chk("R3 setup ack", last_v ? last_c : 0, 1);
        chk("R3 sudav", irq_setup_data, 1);
        rd("R3 byte0", 0, 8'h80);
        rd("R3 byte6", 6, 8'h12);
        wr(9, 3);
        rd("R11 irq cleared", 9, 0);

        // R8 data stage arming
        tok_expect("R8 unarmed IN nak", 1, 0, 2);
        wr(10, 8'h12);
        rd("R8 inbc readback", 10, 8'h12);
        rd("R10 ctrl in_armed", 8, 4);
        tok_expect("R8 armed IN ack", 1, 0, 1);
        tok_expect("R8 disarmed nak", 1, 0, 2);

        // R5/R6 status stage is OUT here
        tok_expect("R5 status hold nak", 0, 0, 2);
        tok_expect("R5 status hold nak again", 0, 0, 2);
        wr(8, 2);
        tok_expect("R6 released status ack", 0, 0, 1);
        tok_expect("R6 after completion nak", 0, 0, 2);

        // R4 rejected setup packets keep the buffer
        setup_pkt(64'h1111_1111_1111_1111, 8, 0, 0);
        chk("R4 bad crc no hs", last_v, 0);
        chk("R4 bad crc no sudav", irq_setup_data, 0);
        rd("R4 buffer kept crc", 0, 8'h80);
        setup_pkt(64'h2222_2222_2222_2222, 7, 1, 0);
        chk("R4 short no hs", last_v, 0);
        rd("R4 buffer kept short", 1, 8'h06);
        setup_pkt(64'h3333_3333_3333_3333, 8, 1, 1);
        chk("R4 data1 no hs", last_v, 0);
        chk("R4 no sudav", irq_setup_data, 0);
        rd("R4 buffer kept data1", 6, 8'h12);
        setup_pkt(64'h4444_4444_4444_4444, 9, 1, 0);
        chk("R4 long no hs", last_v, 0);

        // R11 write zero no effect
        wr(9, 0);
        chk("R11 write0 keeps sutok", irq_setup_tok, 1);
        wr(9, 1);

        // R7 no-data setup: status is IN
        setup_pkt(64'h0000_0000_0001_0900, 8, 1, 0);
        chk("R3 nodata setup ack", last_v ? last_c : 0, 1);
        tok_expect("R7 OUT is data path nak", 0, 0, 2);
        tok_expect("R7 IN status hold nak", 1, 0, 2);
        wr(8, 2);
        tok_expect("R7 IN status ack", 1, 0, 1);

        // R7 OUT-data setup, length 4: status is IN
        setup_pkt(64'h0004_0000_0000_0100, 8, 1, 0);
        tok_expect("R7 IN status hold", 1, 0, 2);
        wr(11, 4);
        tok_expect("R8 armed OUT ack", 0, 0, 1);

        // R9 stall needs both bits
        wr(8, 1);
        tok_expect("R9 stall alone nak", 1, 0, 2);
        wr(8, 3);
        rd("R10 ctrl bits", 8, 3);
        tok_expect("R9 stall both", 0, 0, 3);
        tok_expect("R9 stall status", 1, 0, 3);

        // R3/R10 setup accepted while stalled, bits cleared
        setup_pkt(64'h0000_0000_0000_0500, 8, 1, 0);
        chk("R3 setup under stall ack", last_v ? last_c : 0, 1);
        rd("R10 ctrl cleared", 8, 0);
        tok_expect("R10 hold re-armed", 1, 0, 2);

        repeat (2) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule